// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A single 16-bit counting channel for a multi-channel timer. A set of static configuration inputs chooses what the channel counts and how. It can count edges of an input pin, edges of a neighbouring channel's event line, or ticks of an internal clock divided by a power of two. It can gate, trigger or steer that count with a secondary pin, decode a quadrature pair, or chain onto a neighbour as the upper half of a wider counter.

Each count step moves the value up or down by one. The step that would bring the value to the compare value raises a one-cycle compare pulse. In reload mode that step loads the initial value in place of the compare value. A wrap past all-ones or below zero raises a one-cycle overflow pulse. Both pulses also set sticky flags and drive the channel's event line. A neighbouring channel can select that line as its own primary source, which builds a cascade.

The configuration inputs, the compare value and the load value are treated as register outputs held by logic outside the block. All inputs are assumed to be synchronous to `clk`.

Top module: `mtc_channel`

## Requirements
- R1: After a clock edge with `rst_n` low, `count` is 0 and `cmp_pulse`, `ovf_pulse`, `cmp_flag`, `ovf_flag` and `chan_evt` are all 0.
- R2: With `cfg_mode` = 000 the count does not change on any input activity, except for a forced load under R14.
- R3: With `cfg_mode` = 001 each rising edge of the primary source steps the count once. `cfg_psrc` values 0000 to 0011 select `pin_in[0]` to `pin_in[3]`. Edges on pins that are not selected have no effect.
- R4: With `cfg_mode` = 010 both rising and falling edges of the primary source step the count.
- R5: With `cfg_mode` = 011 a primary rising edge steps the count only while the secondary pin, `pin_in[cfg_ssrc]`, is high.
- R6: With `cfg_mode` = 100 the primary pin (A) and the secondary pin (B) form a quadrature pair. A change of exactly one of them steps the count. The step is up when the new A differs from the previous B, i.e. when A leads; otherwise it is down. Setting `cfg_dir` to 1 swaps the two directions.
- R7: With `cfg_mode` = 101 each primary rising edge steps the count. The step is down when the secondary pin is high and up when it is low, and `cfg_dir` = 1 swaps the two.
- R8: With `cfg_mode` = 110 a secondary rising edge arms the channel. From the next cycle on, primary rising edges step the count, until the step that raises a compare disarms it.
- R9: With `cfg_mode` = 111 the count steps once for every cycle in which the selected neighbour line is high. `cfg_psrc` values 0100 to 0111 select `nbr_evt[0]` to `nbr_evt[3]`.
- R10: `cfg_psrc` values 1000 to 1111 select an internal tick every 2^k cycles, with k = `cfg_psrc[2:0]`. In any window of 2^k·n cycles the count advances exactly n·1 steps in mode 001.
- R11: The step that would bring the count to `cmp_val` raises `cmp_pulse` for one cycle and sets `cmp_flag`. With `cfg_len` = 1 that step loads `load_val` instead, in either direction (`cfg_dir` = 0 up, 1 down). `cmp_flag` stays set until a `flag_clr` cycle without a new compare.
- R12: An up step from 16'hFFFF to 0, or a down step from 0 to 16'hFFFF, that is not replaced by a reload raises `ovf_pulse` for one cycle and sets the sticky `ovf_flag`. `flag_clr` clears that flag. `chan_evt` is the OR of the two pulses.
- R13: With `cfg_once` = 1 the channel stops stepping after its first compare. It resumes only after a cycle with `cfg_mode` = 000.
- R14: When `cfg_coinit` = 1 and `coinit_in` is high, the count loads `load_val` on that edge and no step occurs. When `cfg_coinit` = 0, `coinit_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Count mode |
| cfg_psrc | input | 4 | Primary source select |
| cfg_ssrc | input | 2 | Secondary pin select |
| cfg_once | input | 1 | Stop after first compare |
| cfg_len | input | 1 | Reload on compare (1) or roll over (0) |
| cfg_dir | input | 1 | Count down when 1 |
| cfg_coinit | input | 1 | Allow forced load from another channel |
| pin_in | input | 4 | Input pins |
| nbr_evt | input | 4 | Event lines of neighbouring channels |
| coinit_in | input | 1 | Another channel's compare, forcing a load |
| flag_clr | input | 1 | Clear strobe for both sticky flags |
| cmp_val | input | 16 | Compare value |
| load_val | input | 16 | Initial value for reload and forced load |
| count | output | 16 | Current count |
| cmp_pulse | output | 1 | One-cycle compare event |
| ovf_pulse | output | 1 | One-cycle wrap event |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky wrap flag |
| chan_evt | output | 1 | Event line for cascading |

## Verification
Every result lands on the first rising edge after the input that causes it is sampled. That covers the count step, a reload, a forced load, both pulses and both flags. Arming in the triggered mode takes effect one edge later, so the first triggered step follows the edge after the secondary rise. The bench changes inputs only on falling edges. A behavioural model advances on each rising edge from the same inputs, and the outputs are compared with it at the following falling edge. Directed checks then read the count, pulses and flags at the falling edge after the edge on which each is due.

// File: rtl/mtc_pkg.sv
// Shared constants and the count-mode encoding for the timer channel.
package mtc_pkg;
    localparam int N_PIN = 4;
    localparam int N_NBR = 4;
    localparam int N_DIV = 8;

    typedef enum logic [2:0] {
        MD_IDLE   = 3'b000,
        MD_RISE   = 3'b001,
        MD_BOTH   = 3'b010,
        MD_GATED  = 3'b011,
        MD_QUAD   = 3'b100,
        MD_DIRSEC = 3'b101,
        MD_TRIG   = 3'b110,
        MD_CASC   = 3'b111
    } mode_e;
endpackage

// File: rtl/mtc_prescaler.sv
// Free-running divider. tick[k] is high one cycle in every 2^k.
// Assumes N_DIV >= 2; tick[0] is constantly high.
module mtc_prescaler #(
    parameter int N_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [N_DIV-1:0] tick
);
    localparam int PW = N_DIV - 1;

    logic [PW-1:0] pre;

    // Advance the divider chain every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pre <= '0;
        else        pre <= pre + 1'b1;
    end

    assign tick[0] = 1'b1;
    for (genvar k = 1; k < N_DIV; k++) begin : g_tap
        assign tick[k] = &pre[k-1:0];
    end
endmodule

// File: rtl/mtc_src_sel.sv
// Picks the primary and secondary levels and derives their edges.
// Pin and neighbour sources use a registered previous level; a prescaler
// tick is treated as a rising edge on its own. Inputs are synchronous.
module mtc_src_sel
    import mtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pins,
    input  logic [N_NBR-1:0] nbr,
    input  logic [N_DIV-1:0] ticks,
    input  logic [3:0]       psrc,
    input  logic [1:0]       ssrc,
    output logic             pri_lvl,
    output logic             pri_prev,
    output logic             pri_rise,
    output logic             pri_fall,
    output logic             sec_lvl,
    output logic             sec_prev,
    output logic             sec_rise
);
    logic pri_is_tick;

    // Decode the primary select into a level and its edges.
    always_comb begin
        pri_is_tick = psrc[3];
        case (psrc[3:2])
            2'b00:   pri_lvl = pins[psrc[1:0]];
            2'b01:   pri_lvl = nbr[psrc[1:0]];
            default: pri_lvl = ticks[psrc[2:0]];
        endcase
        pri_rise = pri_is_tick ? pri_lvl : (pri_lvl & ~pri_prev);
        pri_fall = pri_is_tick ? 1'b0    : (~pri_lvl & pri_prev);
        sec_lvl  = pins[ssrc];
        sec_rise = sec_lvl & ~sec_prev;
    end

    // Remember last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_prev <= 1'b0;
            sec_prev <= 1'b0;
        end else begin
            pri_prev <= pri_lvl;
            sec_prev <= sec_lvl;
        end
    end
endmodule

// File: rtl/mtc_step_ctrl.sv
// Turns the mode and source edges into a step request and direction.
// Holds the arm state of the triggered mode; hit comes from the counter.
module mtc_step_ctrl
    import mtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  cfg_dir,
    input  logic  pri_lvl,
    input  logic  pri_prev,
    input  logic  pri_rise,
    input  logic  pri_fall,
    input  logic  sec_lvl,
    input  logic  sec_prev,
    input  logic  sec_rise,
    input  logic  hit,
    output logic  step_req,
    output logic  step_dn
);
    logic armed;

    // Mode decode: which event steps the count, and which way.
    always_comb begin
        step_req = 1'b0;
        step_dn  = cfg_dir;
        case (mode)
            MD_RISE:   step_req = pri_rise;
            MD_BOTH:   step_req = pri_rise | pri_fall;
            MD_GATED:  step_req = pri_rise & sec_lvl;
            MD_QUAD: begin
                step_req = (pri_lvl ^ pri_prev) ^ (sec_lvl ^ sec_prev);
                step_dn  = ~(sec_prev ^ pri_lvl) ^ cfg_dir;
            end
            MD_DIRSEC: begin
                step_req = pri_rise;
                step_dn  = sec_lvl ^ cfg_dir;
            end
            MD_TRIG:   step_req = armed & pri_rise;
            MD_CASC:   step_req = pri_lvl;
            default:   step_req = 1'b0;
        endcase
    end

    // Arm on a secondary rise, disarm on compare or leaving the mode.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed <= 1'b0;
        else if (mode != MD_TRIG) armed <= 1'b0;
        else if (hit)            armed <= 1'b0;
        else if (sec_rise)       armed <= 1'b1;
    end

    // A compare in triggered mode blocks stepping on the next cycle.
    assert_trig_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!step_req || mode != MD_TRIG));
endmodule

// File: rtl/mtc_counter.sv
// Count register with compare, reload, wrap, one-shot halt and flags.
// Compare is taken on the value a step would produce.
module mtc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_req,
    input  logic          step_dn,
    input  logic          force_ld,
    input  logic          cfg_len,
    input  logic          cfg_once,
    input  logic          mode_idle,
    input  logic          flag_clr,
    input  logic [CW-1:0] cmp_val,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          hit,
    output logic          cmp_pulse,
    output logic          ovf_pulse,
    output logic          cmp_flag,
    output logic          ovf_flag
);
    logic          halted;
    logic          step;
    logic          wrap;
    logic          reload;
    logic [CW-1:0] nxt;

    // Next value and event detection for an effective step.
    always_comb begin
        step   = step_req & ~halted & ~force_ld;
        nxt    = step_dn ? count - 1'b1 : count + 1'b1;
        hit    = step & (nxt == cmp_val);
        wrap   = step & (step_dn ? (count == '0) : (count == '1));
        reload = hit & cfg_len;
    end

    // Update count and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            cmp_pulse <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            cmp_pulse <= hit;
            ovf_pulse <= wrap & ~reload;
            if (force_ld)    count <= load_val;
            else if (reload) count <= load_val;
            else if (step)   count <= nxt;
        end
    end

    // One-shot halt, released by the idle mode.
    always_ff @(posedge clk) begin
        if (!rst_n)               halted <= 1'b0;
        else if (mode_idle)       halted <= 1'b0;
        else if (hit && cfg_once) halted <= 1'b1;
    end

    // Sticky flags, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (hit)           cmp_flag <= 1'b1;
            else if (flag_clr) cmp_flag <= 1'b0;
            if (wrap & ~reload) ovf_flag <= 1'b1;
            else if (flag_clr)  ovf_flag <= 1'b0;
        end
    end

    assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_req && !force_ld) |=> $stable(count));
    assert_cmp_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);
    assert_ovf_lands_on_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0 || count == '1));
    assert_once_freezes_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pulse && $past(cfg_once) && !force_ld) |=> $stable(count));
    assert_force_loads_R14: assert property (@(posedge clk) disable iff (!rst_n)
        force_ld |=> (count == $past(load_val)));
endmodule

// File: rtl/mtc_channel.sv
// Top of one timer channel: prescaler, source select, step control and
// counter. Configuration inputs are static register outputs from outside.
module mtc_channel
    import mtc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_mode,
    input  logic [3:0]    cfg_psrc,
    input  logic [1:0]    cfg_ssrc,
    input  logic          cfg_once,
    input  logic          cfg_len,
    input  logic          cfg_dir,
    input  logic          cfg_coinit,
    input  logic [3:0]    pin_in,
    input  logic [3:0]    nbr_evt,
    input  logic          coinit_in,
    input  logic          flag_clr,
    input  logic [CW-1:0] cmp_val,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          cmp_pulse,
    output logic          ovf_pulse,
    output logic          cmp_flag,
    output logic          ovf_flag,
    output logic          chan_evt
);
    mode_e            mode;
    logic [N_DIV-1:0] ticks;
    logic pri_lvl, pri_prev, pri_rise, pri_fall;
    logic sec_lvl, sec_prev, sec_rise;
    logic step_req, step_dn, hit, force_ld;

    assign mode     = mode_e'(cfg_mode);
    assign force_ld = cfg_coinit & coinit_in;
    assign chan_evt = cmp_pulse | ovf_pulse;

    mtc_prescaler #(.N_DIV(N_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(ticks)
    );

    mtc_src_sel u_src (
        .clk(clk), .rst_n(rst_n), .pins(pin_in), .nbr(nbr_evt),
        .ticks(ticks), .psrc(cfg_psrc), .ssrc(cfg_ssrc),
        .pri_lvl(pri_lvl), .pri_prev(pri_prev), .pri_rise(pri_rise),
        .pri_fall(pri_fall), .sec_lvl(sec_lvl), .sec_prev(sec_prev),
        .sec_rise(sec_rise)
    );

    mtc_step_ctrl u_step (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_dir(cfg_dir),
        .pri_lvl(pri_lvl), .pri_prev(pri_prev), .pri_rise(pri_rise),
        .pri_fall(pri_fall), .sec_lvl(sec_lvl), .sec_prev(sec_prev),
        .sec_rise(sec_rise), .hit(hit), .step_req(step_req),
        .step_dn(step_dn)
    );

    mtc_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_dn(step_dn),
        .force_ld(force_ld), .cfg_len(cfg_len), .cfg_once(cfg_once),
        .mode_idle(mode == MD_IDLE), .flag_clr(flag_clr),
        .cmp_val(cmp_val), .load_val(load_val), .count(count), .hit(hit),
        .cmp_pulse(cmp_pulse), .ovf_pulse(ovf_pulse),
        .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
    );
endmodule

// File: tb/mtc_channel_tb.sv
`timescale 1ns/1ps
module mtc_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic [3:0]  psrc = 4'b0000;
    logic [1:0]  ssrc = 2'b01;
    logic        once = 1'b0, len = 1'b0, dir = 1'b0, coen = 1'b1;
    logic [3:0]  pins = 4'b0000, nbr = 4'b0000;
    logic        coin = 1'b0, fclr = 1'b0;
    logic [15:0] cmpv = 16'h8000, ldv = 16'h0000;
    logic [15:0] count;
    logic        cmp_pulse, ovf_pulse, cmp_flag, ovf_flag, chan_evt;

    int    tests = 0, fails = 0;
    string cur_req = "R1";
    bit    started = 1'b0;

    // reference model state
    logic [15:0] m_cnt;
    bit m_cp, m_op, m_cf, m_of, m_halt, m_arm, m_pp, m_sp;
    int m_pre;

    always #2.5 clk = ~clk;

    mtc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_psrc(psrc),
        .cfg_ssrc(ssrc), .cfg_once(once), .cfg_len(len), .cfg_dir(dir),
        .cfg_coinit(coen), .pin_in(pins), .nbr_evt(nbr), .coinit_in(coin),
        .flag_clr(fclr), .cmp_val(cmpv), .load_val(ldv), .count(count),
        .cmp_pulse(cmp_pulse), .ovf_pulse(ovf_pulse), .cmp_flag(cmp_flag),
        .ovf_flag(ovf_flag), .chan_evt(chan_evt)
    );

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        bit pl, sl, pr, pf, sr, stp, dn, hit, wrap, frc;
        logic [15:0] nx;
        int k;
        if (!rst_n) begin
            m_cnt = 0; m_cp = 0; m_op = 0; m_cf = 0; m_of = 0;
            m_halt = 0; m_arm = 0; m_pp = 0; m_sp = 0; m_pre = 0;
            started = 1'b1;
        end else begin
            if (psrc < 4) begin
                pl = pins[psrc[1:0]]; pr = pl && !m_pp; pf = !pl && m_pp;
            end else if (psrc < 8) begin
                pl = nbr[psrc[1:0]]; pr = pl && !m_pp; pf = !pl && m_pp;
            end else begin
                k = int'(psrc) - 8;
                pl = ((m_pre % (1 << k)) == (1 << k) - 1); pr = pl; pf = 0;
            end
            sl = pins[ssrc]; sr = sl && !m_sp;
            stp = 0; dn = dir;
            case (mode)
                3'd1: stp = pr;
                3'd2: stp = pr || pf;
                3'd3: stp = pr && sl;
                3'd4: begin
                    stp = ((pl != m_pp) != (sl != m_sp));
                    dn  = (m_sp == pl) ? !dir : dir;
                end
                3'd5: begin stp = pr; dn = sl ? !dir : dir; end
                3'd6: stp = pr && m_arm;
                3'd7: stp = pl;
                default: stp = 0;
            endcase
            frc = coen && coin;
            if (frc || m_halt) stp = 0;
            nx   = dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
            hit  = stp && (nx == cmpv);
            wrap = stp && (dn ? (m_cnt == 16'h0000) : (m_cnt == 16'hFFFF));
            m_cp = hit;
            m_op = wrap && !(hit && len);
            if (frc) m_cnt = ldv;
            else if (hit && len) m_cnt = ldv;
            else if (stp) m_cnt = nx;
            if (hit) m_cf = 1; else if (fclr) m_cf = 0;
            if (m_op) m_of = 1; else if (fclr) m_of = 0;
            if (mode == 3'd0) m_halt = 0; else if (hit && once) m_halt = 1;
            if (mode != 3'd6) m_arm = 0; else if (hit) m_arm = 0; else if (sr) m_arm = 1;
            m_pp = pl; m_sp = sl;
            m_pre = (m_pre + 1) % 128;
        end
    end

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (started) begin
            logic [20:0] act, exp;
            act = {count, cmp_pulse, ovf_pulse, cmp_flag, ovf_flag, chan_evt};
            exp = {m_cnt, m_cp, m_op, m_cf, m_of, m_cp | m_op};
            tests++;
            if (act !== exp) begin
                fails++;
                $display("FAIL %s model mismatch: actual %h expected %h", cur_req, act, exp);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pin_pulse(input int i);
        pins[i] = 1'b1; cyc(2);
        pins[i] = 1'b0; cyc(2);
    endtask

    task automatic load(input logic [15:0] v);
        ldv = v; coen = 1'b1; coin = 1'b1; cyc(1);
        coin = 1'b0;
    endtask

    task automatic clear_flags();
        fclr = 1'b1; cyc(1); fclr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int c0;
        cyc(3);
        // R1 reset state
        chk("R1", count, 0); chk("R1", cmp_flag, 0); chk("R1", ovf_flag, 0);
        chk("R1", chan_evt, 0);
        rst_n = 1'b1; cyc(1);

        cur_req = "R2";
        for (int i = 0; i < 3; i++) pin_pulse(0);
        chk("R2", count, 0);

        cur_req = "R3";
        mode = 3'b001; psrc = 4'b0000;
        for (int i = 0; i < 5; i++) pin_pulse(0);
        pin_pulse(2);
        chk("R3", count, 5);
        psrc = 4'b0010; cyc(1);
        pin_pulse(2); pin_pulse(2);
        chk("R3", count, 7);

        cur_req = "R4";
        mode = 3'b010; psrc = 4'b0000; load(0);
        for (int i = 0; i < 3; i++) pin_pulse(0);
        chk("R4", count, 6);

        cur_req = "R5";
        mode = 3'b011; ssrc = 2'b01; load(0);
        pin_pulse(0); pin_pulse(0);
        chk("R5", count, 0);
        pins[1] = 1'b1; cyc(1);
        for (int i = 0; i < 3; i++) pin_pulse(0);
        pins[1] = 1'b0; cyc(1);
        chk("R5", count, 3);

        cur_req = "R6";
        mode = 3'b100; load(100);
        for (int r = 0; r < 2; r++) begin
            pins[1:0] = 2'b01; cyc(1); pins[1:0] = 2'b11; cyc(1);
            pins[1:0] = 2'b10; cyc(1); pins[1:0] = 2'b00; cyc(1);
        end
        chk("R6", count, 108);
        pins[1:0] = 2'b10; cyc(1); pins[1:0] = 2'b11; cyc(1);
        pins[1:0] = 2'b01; cyc(1); pins[1:0] = 2'b00; cyc(1);
        chk("R6", count, 104);

        cur_req = "R7";
        mode = 3'b101; load(50);
        pin_pulse(0); pin_pulse(0);
        chk("R7", count, 52);
        pins[1] = 1'b1; cyc(1);
        for (int i = 0; i < 3; i++) pin_pulse(0);
        pins[1] = 1'b0; cyc(1);
        chk("R7", count, 49);

        cur_req = "R8";
        mode = 3'b000; load(0);
        len = 1'b1; cmpv = 16'd4; psrc = 4'b1000; mode = 3'b110; cyc(3);
        chk("R8", count, 0);
        pins[1] = 1'b1; cyc(1); pins[1] = 1'b0; cyc(2);
        chk("R8", count, 2);
        cyc(6);
        chk("R8", count, 0); chk("R8", cmp_flag, 1);
        clear_flags(); len = 1'b0; cmpv = 16'h8000;

        cur_req = "R9";
        mode = 3'b111; psrc = 4'b0101; load(0);
        nbr[1] = 1'b1; cyc(3); nbr[1] = 1'b0; cyc(1);
        nbr[2] = 1'b1; cyc(2); nbr[2] = 1'b0; cyc(1);
        chk("R9", count, 3);

        cur_req = "R10";
        mode = 3'b001; psrc = 4'b1011; load(0);
        c0 = count; cyc(64); chk("R10", (count - c0) & 16'hFFFF, 8);
        psrc = 4'b1111; cyc(1);
        c0 = count; cyc(256); chk("R10", (count - c0) & 16'hFFFF, 2);
        psrc = 4'b1000; cyc(1);
        c0 = count; cyc(10); chk("R10", (count - c0) & 16'hFFFF, 10);

        cur_req = "R11";
        mode = 3'b000; len = 1'b1; cmpv = 16'd5; load(0); clear_flags();
        mode = 3'b001; cyc(4);
        chk("R11", count, 4);
        cyc(1);
        chk("R11", count, 0); chk("R11", cmp_pulse, 1); chk("R11", cmp_flag, 1);
        cyc(1);
        chk("R11", count, 1); chk("R11", cmp_pulse, 0); chk("R11", cmp_flag, 1);
        clear_flags();
        chk("R11", cmp_flag, 0);
        mode = 3'b000; dir = 1'b1; cmpv = 16'd7; load(10);
        mode = 3'b001; cyc(2);
        chk("R11", count, 8);
        cyc(1);
        chk("R11", count, 10); chk("R11", cmp_pulse, 1);

        cur_req = "R12";
        mode = 3'b000; dir = 1'b0; len = 1'b0; cmpv = 16'h8000; load(16'hFFFD);
        clear_flags();
        mode = 3'b001; cyc(2);
        chk("R12", count, 16'hFFFF);
        cyc(1);
        chk("R12", count, 0); chk("R12", ovf_pulse, 1); chk("R12", chan_evt, 1);
        chk("R12", ovf_flag, 1);
        mode = 3'b000; clear_flags(); chk("R12", ovf_flag, 0);
        dir = 1'b1; load(1);
        mode = 3'b001; cyc(1);
        chk("R12", count, 0);
        cyc(1);
        chk("R12", count, 16'hFFFF); chk("R12", ovf_pulse, 1);
        mode = 3'b000; clear_flags();

        cur_req = "R13";
        dir = 1'b0; len = 1'b1; once = 1'b1; cmpv = 16'd3; load(0);
        mode = 3'b001; cyc(2);
        chk("R13", count, 2);
        cyc(1);
        chk("R13", count, 0); chk("R13", cmp_pulse, 1);
        cyc(5);
        chk("R13", count, 0);
        mode = 3'b000; cyc(1);
        mode = 3'b001; cyc(2);
        chk("R13", count, 2);
        once = 1'b0; len = 1'b0; cmpv = 16'h8000; mode = 3'b000; cyc(1);

        cur_req = "R14";
        load(0);
        coen = 1'b0; ldv = 16'd77; coin = 1'b1; mode = 3'b001; cyc(2);
        chk("R14", count, 2);
        coen = 1'b1; cyc(1);
        chk("R14", count, 77);
        coin = 1'b0; mode = 3'b000; cyc(2);
        chk("R14", count, 77);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule